// File: doc/BRIEF.md
# Parallel EEPROM Byte Programming Sequencer

This block writes a stream of bytes into a byte-wide parallel EEPROM at consecutive addresses, beginning at zero. It returns each byte as it reads it back from the device. A byte arrives through a valid/ready handshake. The sequencer then sends the current 16-bit address to two chained serial-in shift registers that drive the device address pins. It writes the byte with chip enable and write enable and releases the data bus. It then polls the device until the internal write cycle is over, and finally reads the location back.

Write completion is found by toggle polling. Reads are taken in pairs, and only the upper six data bits are compared. Polling stops as soon as both reads of one pair agree. A final full read then supplies the byte that goes out through a second valid/ready handshake. No new byte is accepted until that result has been taken.

Top module: `eeprom_prog_seq`

## Requirements
- R1: During and after reset, `ce_n`, `we_n` and `oe_n` are 1, `bus_oe` and `sr_clk` are 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The address used for the N-th accepted byte (counting from 0) is N modulo 2^16. A carry out of the low address byte goes into the high byte, so byte 256 uses address 0x0100.
- R3: Each address is sent as 16 bits, most significant bit first, so the high byte goes before the low byte. There is one bit per rising edge of `sr_clk` and exactly 16 rising edges per byte. `sr_data` does not change in the cycle where `sr_clk` rises.
- R4: The write proceeds in this order, one step per cycle: `ce_n` falls, then `we_n` falls, then `bus_oe` rises with `bus_out` equal to the byte, then `we_n` rises, then `ce_n` rises in the same cycle that `bus_oe` falls. `we_n` is low only while `ce_n` is low.
- R5: `bus_oe` is 1 only while `ce_n` is 0 and `oe_n` is 1. `we_n` and `oe_n` are never low together.
- R6: Every read lowers `ce_n` and `oe_n` in the same cycle and keeps them low for SETTLE_CYC cycles (default 3). Before the first read, both stay high for SETTLE_CYC cycles after the write.
- R7: Poll reads come in pairs, and only bits 7:2 of the two samples are compared. A difference in bits 1:0 alone counts as a match. Pairs repeat until they match, and then one more read captures all 8 bits.
- R8: The final read value appears on `out_data` with `out_valid`=1. Both are held unchanged until a cycle with `out_ready`=1.
- R9: `in_ready` is 0 from acceptance of a byte until its read-back has been taken. While `in_ready` is 1, `ce_n`, `we_n` and `oe_n` are 1 and `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte to program is offered |
| in_data | input | 8 | Byte to program |
| in_ready | output | 1 | Sequencer can take a byte |
| out_valid | output | 1 | Read-back byte available |
| out_data | output | 8 | Read-back byte |
| out_ready | input | 1 | Consumer takes the read-back byte |
| sr_data | output | 1 | Serial data into the address shift chain |
| sr_clk | output | 1 | Shift clock for the address chain |
| ce_n | output | 1 | Device chip enable, active low |
| we_n | output | 1 | Device write enable, active low |
| oe_n | output | 1 | Device output enable, active low |
| bus_out | output | 8 | Data driven onto the device bus |
| bus_oe | output | 1 | Drive enable for bus_out |
| bus_in | input | 8 | Data bus as seen from the device |

## Verification
Two things can land in the same cycle. A stalled read-back handshake, with `out_valid` high and `out_ready` low, can coincide with a new byte waiting on `in_valid`, and acceptance must not start until the output is taken. A poll pair can also differ only in bits 1:0 at the moment polling must decide to stop. The bench drives `out_ready` randomly while a byte is always waiting, and checks at every cycle that `in_ready` stays low and `out_data` stays stable. A device model returns toggling, stable, or low-bit-noise reads per byte, and the bench judges the number of reads the sequencer takes against a count worked out from that schedule.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_W_CE,
    ST_W_WE,
    ST_W_DRV,
    ST_W_WEH,
    ST_HOLD,
    ST_RD_ON,
    ST_RD_OFF
  } seq_state_t;

  typedef enum logic [1:0] {
    RD_POLL_A,
    RD_POLL_B,
    RD_FINAL
  } rd_kind_t;

endpackage

// File: rtl/seq_addr_shift.sv
module seq_addr_shift #(
  parameter int ADDR_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sr_data,
  output logic sr_clk,
  output logic done
);
  localparam int BW = $clog2(ADDR_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(ADDR_W - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic              busy_q;
  logic              hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      sh_q    <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      hi_q    <= 1'b0;
      sr_data <= 1'b0;
      sr_clk  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        sh_q    <= addr_q;
        sr_data <= addr_q[ADDR_W-1];
        bit_q   <= '0;
        hi_q    <= 1'b0;
        busy_q  <= 1'b1;
        sr_clk  <= 1'b0;
      end else if (busy_q) begin
        if (!hi_q) begin
          sr_clk <= 1'b1;
          hi_q   <= 1'b1;
        end else begin
          sr_clk <= 1'b0;
          hi_q   <= 1'b0;
          if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
            addr_q <= addr_q + 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            sh_q    <= {sh_q[ADDR_W-2:0], 1'b0};
            sr_data <= sh_q[ADDR_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst || !run || expired) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 3,
  parameter int POLL_LSB   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              sr_data,
  output logic              sr_clk,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in
);
  localparam int PW = DATA_W - POLL_LSB;

  seq_state_t        state_q;
  rd_kind_t          kind_q;
  logic [DATA_W-1:0] wr_q;
  logic [PW-1:0]     samp_a_q;
  logic [PW-1:0]     samp_b_q;
  logic              sh_start_q;
  logic              sh_done;
  logic              tmr_run;
  logic              tmr_exp;

  seq_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start_q),
    .sr_data (sr_data),
    .sr_clk  (sr_clk),
    .done    (sh_done)
  );

  assign tmr_run = (state_q == ST_HOLD) || (state_q == ST_RD_ON);

  seq_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  assign in_ready = (state_q == ST_IDLE) && !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      kind_q     <= RD_POLL_A;
      wr_q       <= '0;
      samp_a_q   <= '0;
      samp_b_q   <= '0;
      sh_start_q <= 1'b0;
      ce_n       <= 1'b1;
      we_n       <= 1'b1;
      oe_n       <= 1'b1;
      bus_oe     <= 1'b0;
      bus_out    <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      sh_start_q <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid && in_ready) begin
            wr_q       <= in_data;
            sh_start_q <= 1'b1;
            state_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            ce_n    <= 1'b0;
            state_q <= ST_W_CE;
          end
        end
        ST_W_CE: begin
          we_n    <= 1'b0;
          state_q <= ST_W_WE;
        end
        ST_W_WE: begin
          bus_oe  <= 1'b1;
          bus_out <= wr_q;
          state_q <= ST_W_DRV;
        end
        ST_W_DRV: begin
          we_n    <= 1'b1;
          state_q <= ST_W_WEH;
        end
        ST_W_WEH: begin
          ce_n    <= 1'b1;
          bus_oe  <= 1'b0;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_exp) begin
            ce_n    <= 1'b0;
            oe_n    <= 1'b0;
            kind_q  <= RD_POLL_A;
            state_q <= ST_RD_ON;
          end
        end
        ST_RD_ON: begin
          if (tmr_exp) begin
            unique case (kind_q)
              RD_POLL_A: samp_a_q <= bus_in[DATA_W-1:POLL_LSB];
              RD_POLL_B: samp_b_q <= bus_in[DATA_W-1:POLL_LSB];
              default:   out_data <= bus_in;
            endcase
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            state_q <= ST_RD_OFF;
          end
        end
        ST_RD_OFF: begin
          if (kind_q == RD_FINAL) begin
            out_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            if (kind_q == RD_POLL_A)        kind_q <= RD_POLL_B;
            else if (samp_a_q == samp_b_q)  kind_q <= RD_FINAL;
            else                            kind_q <= RD_POLL_A;
            ce_n    <= 1'b0;
            oe_n    <= 1'b0;
            state_q <= ST_RD_ON;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_prog_seq_chk.sv
module eeprom_prog_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              sr_data,
  input logic              sr_clk,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              bus_oe
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ce_n && we_n && oe_n && !bus_oe && !out_valid && !sr_clk));

  p_shift_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_clk) |-> $stable(sr_data));

  p_shift_idle_ce_r3: assert property (@(posedge clk) disable iff (rst)
    sr_clk |-> (ce_n && we_n && oe_n));

  p_we_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);

  p_drive_window_r5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!ce_n && oe_n));

  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  p_read_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> $fell(ce_n));

  p_read_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> $rose(ce_n));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_accept_pending_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_idle_pins_r9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (ce_n && we_n && oe_n && !bus_oe));
endmodule

bind eeprom_prog_seq eeprom_prog_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/eeprom_prog_seq_tb.sv
module eeprom_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int NB         = 300;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       sr_data, sr_clk, ce_n, we_n, oe_n, bus_oe;
  logic [7:0] bus_out;
  logic [7:0] bus_in = '0;

  eeprom_prog_seq #(.SETTLE_CYC(SETTLE)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_byte [NB];
  int         tog      [NB];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int reads_expected(input int t);
    if (t < 0) return 3;
    return 2 * ((t + 1) / 2 + 1) + 1;
  endfunction

  function automatic logic [7:0] read_value(input logic [7:0] d, input int t, input int n);
    if (t < 0) return (n < 2) ? (d ^ 8'(n + 1)) : d;
    if (n < t) return d ^ ((n % 2 == 1) ? 8'hC0 : 8'h80);
    return d;
  endfunction

  // device and pin monitor
  logic [15:0] sh_cap = '0;
  int pulses = 0, wr_idx = 0, out_idx = 0, nreads = 0, low_cnt = 0;
  bit wphase = 0, hold_prev = 0;
  logic p_sr = 0, p_we = 1, p_ce = 1, p_oe = 1, p_boe = 0, p_ov = 0;
  logic [7:0] stored = '0, p_od = '0;
  bit stress = 0;

  always @(negedge clk) begin
    if (!rst) begin
      out_ready = stress ? (($urandom % 4) == 0) : (($urandom % 2) == 0);
      if (sr_clk && !p_sr) begin sh_cap = {sh_cap[14:0], sr_data}; pulses++; end
      if (!we_n && p_we) begin
        check(sh_cap == 16'(wr_idx), "R2 address", sh_cap, wr_idx);
        check(pulses == 16, "R3 shift pulses", pulses, 16);
        check(!ce_n && !bus_oe, "R4 ce before we", {ce_n, bus_oe}, 0);
        pulses = 0; wphase = 1;
      end
      if (bus_oe && !p_boe)
        check(!we_n && bus_out == exp_byte[wr_idx], "R4 bus drive", bus_out, exp_byte[wr_idx]);
      if (we_n && !p_we) begin
        check(bus_oe && bus_out == exp_byte[wr_idx], "R4 data at we rise", bus_out, exp_byte[wr_idx]);
        stored = bus_out; nreads = 0; low_cnt = 0;
      end
      if (ce_n && !p_ce && wphase) begin
        check(!bus_oe && we_n, "R4 release with ce", {bus_oe, we_n}, 2'b01);
        wphase = 0; wr_idx++;
      end
      if (!oe_n && p_oe) begin
        if (nreads == 0) check(low_cnt == SETTLE, "R6 post-write hold", low_cnt, SETTLE);
        bus_in = read_value(stored, tog[wr_idx-1], nreads);
        nreads++; low_cnt = 0;
      end
      if (oe_n && !p_oe) check(low_cnt == SETTLE, "R6 read width", low_cnt, SETTLE);
      if (oe_n && ce_n && !wphase && wr_idx > 0 && !out_valid) low_cnt = low_cnt + (nreads == 0 ? 1 : 0);
      if (!oe_n) low_cnt++;
      if (out_valid && !p_ov)
        check(nreads == reads_expected(tog[out_idx]), "R7 poll count", nreads, reads_expected(tog[out_idx]));
      if (p_ov && !out_ready_prev)
        check(out_valid && out_data == p_od, "R8 held output", out_data, p_od);
      if (out_valid) check(!in_ready, "R9 no accept while pending", in_ready, 0);
      if (out_valid && out_ready) begin
        check(out_data == exp_byte[out_idx], "R8 read-back", out_data, exp_byte[out_idx]);
        out_idx++;
      end
      p_sr = sr_clk; p_we = we_n; p_ce = ce_n; p_oe = oe_n; p_boe = bus_oe;
      p_ov = out_valid; p_od = out_data; out_ready_prev = out_ready;
    end
  end
  logic out_ready_prev = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WDOG);
    check(0, "watchdog", out_idx, NB);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      exp_byte[i] = 8'($urandom);
      tog[i] = (i % 7 == 3) ? -1 : int'($urandom % 5);
    end
    tog[0] = 0; tog[1] = -1; tog[2] = 1; tog[3] = 2; tog[4] = 5;
    exp_byte[0] = 8'h00; exp_byte[1] = 8'hFF; exp_byte[2] = 8'hA5;
    repeat (4) @(negedge clk);
    check(ce_n && we_n && oe_n && !bus_oe && !sr_clk && !out_valid, "R1 pins in reset",
          {ce_n, we_n, oe_n, bus_oe, sr_clk, out_valid}, 6'b111000);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready && ce_n && we_n && oe_n && !bus_oe, "R1 idle after reset",
          {in_ready, ce_n, we_n, oe_n, bus_oe}, 5'b11110);
    for (int i = 0; i < NB; i++) begin
      stress = (i >= 5 && i < 15);
      in_valid = 1'b1;
      in_data  = exp_byte[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(!in_ready, "R9 busy after accept", in_ready, 0);
      if (!stress) repeat ($urandom % 3) @(negedge clk);
    end
    while (out_idx < NB) @(negedge clk);
    check(wr_idx == NB, "R2 write count", wr_idx, NB);
    finish_run();
  end
endmodule